// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks exclusive reservations for a memory-side completion path. Each time a write-class request completes, the block receives the line address, an operation code and the identifier of the requester. A completing load-linked records a reservation on its line for that requester. A completing store-conditional is resolved against the recorded reservations. Its outcome is returned one cycle later as a full-width word holding 1 for success or 0 for failure. Plain writes and locked read-modify-write halves can cancel a reservation owned by their own requester. All decisions are made at completion time only.

The reservation store holds a parameterised number of entries. Each entry has a valid bit, a line tag, an owner id and an age rank. New load-linked operations fill a free entry first. When every entry is in use, the new operation evicts the least recently armed entry. A separate two-state machine, with states `S_OPEN` and `S_HELD`, handles locked read-modify-write. The transition *take* (`S_OPEN` to `S_HELD`) happens on a locked-read completion and latches that line. The transition *release* (`S_HELD` to `S_OPEN`) happens on a locked-write completion to the latched line. Every other event leaves the state where it is.

A probe port lets the neighbouring request logic ask whether a line is reserved, who owns it, and whether the line is blocked. A bypass input freezes the reservation store and makes every store-conditional report success.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked completion (code 0) arms a reservation on its line for its requester. From the next cycle the probe reports that line as reserved with that owner. A load-linked to a line reserved by another requester moves ownership to the new requester.
- R2: A store-conditional completion (code 1) raises `sc_done` for exactly one cycle, in the cycle after the completion. `sc_word` is 1 if the line is reserved for the same requester and 0 otherwise. No other code raises `sc_done`.
- R3: Every store-conditional removes the reservation on its line, whatever its outcome and whichever requester owns the line.
- R4: A plain write (code 2), a locked read (code 3) or a locked write (code 4) removes the reservation on its line only when the line is reserved by the same requester. Reservations on other lines are untouched.
- R5: With all entries in use, a load-linked to a new line evicts the entry whose reservation was armed least recently. Re-arming an existing line makes it the most recent. A free entry is always used before any eviction. `resv_count` reports the number of live entries.
- R6: A locked read (code 3) in state `S_OPEN` blocks its line. A locked write (code 4) to the blocked line unblocks it. A locked write to any other line, or a locked read while a line is already blocked, changes nothing.
- R7: While `bypass` is high, no reservation is armed or removed, and every store-conditional returns 1. Line blocking still operates.
- R8: Reset clears every reservation, the line block and `sc_done`.
- R9: Codes 5, 6 and 7 have no effect on reservations, on blocking or on `sc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass | input | 1 | Freeze reservations and report every store-conditional as successful |
| cmp_valid | input | 1 | A completion is presented this cycle |
| cmp_kind | input | 3 | Operation code: 0 load-linked, 1 store-conditional, 2 plain write, 3 locked read, 4 locked write |
| cmp_line | input | LINE_W | Line address of the completion |
| cmp_owner | input | ID_W | Requester identifier of the completion |
| probe_line | input | LINE_W | Line to query |
| sc_done | output | 1 | Store-conditional result valid |
| sc_word | output | WORD_W | Store-conditional result: 1 success, 0 failure |
| probe_reserved | output | 1 | Probed line holds a reservation |
| probe_owner | output | ID_W | Owner of the probed reservation (0 when none) |
| probe_blocked | output | 1 | Probed line is blocked by a locked read |
| resv_count | output | CNT_W | Number of live reservations |

## Verification
The bench checks that a store-conditional from a non-owner still destroys the reservation. A design that cleared only on success would let the real owner succeed afterwards. It also checks that a plain write from a different requester, or to a neighbouring line, leaves the reservation alone. An over-eager clear shows up as a failed store-conditional later on. Eviction order is exercised with a re-armed entry and a freed slot. A plain FIFO or lowest-index victim evicts the wrong line, and a design that ignores free slots drops a live reservation. Bypass is checked to both freeze the store and report success while still honouring line blocks, and stray codes are checked to produce no result pulse.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [2:0] {
        K_LL   = 3'd0,
        K_SC   = 3'd1,
        K_WR   = 3'd2,
        K_LKRD = 3'd3,
        K_LKWR = 3'd4
    } cmp_kind_e;

    typedef enum logic {
        S_OPEN = 1'b0,
        S_HELD = 1'b1
    } lock_state_e;

endpackage

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
    parameter int LINE_W  = 26,
    parameter int ID_W    = 4,
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_ll,
    input  logic              do_kill,
    input  logic              do_wclr,
    input  logic [LINE_W-1:0] line,
    input  logic [ID_W-1:0]   owner,
    input  logic [LINE_W-1:0] probe_line,
    output logic              own_hit,
    output logic              probe_hit,
    output logic [ID_W-1:0]   probe_owner,
    output logic [CNT_W-1:0]  count
);
    localparam int REF_W = IDX_W + 1;

    logic [ENTRIES-1:0] vld;
    logic [LINE_W-1:0]  tag [ENTRIES];
    logic [ID_W-1:0]    own [ENTRIES];
    logic [IDX_W-1:0]   age [ENTRIES];

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] old_vec;
    logic               hit_any, free_any, clr_now;
    logic [IDX_W-1:0]   hit_idx, free_idx, victim_idx, slot;
    logic [REF_W-1:0]   ref_age;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign hit_vec[g] = vld[g] && (tag[g] == line);
        assign old_vec[g] = vld[g] && (age[g] == IDX_W'(ENTRIES - 1));
    end

    always_comb begin
        hit_idx    = '0;
        free_idx   = '0;
        victim_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx    = IDX_W'(i);
            if (!vld[i])    free_idx   = IDX_W'(i);
            if (old_vec[i]) victim_idx = IDX_W'(i);
        end
    end

    assign hit_any  = |hit_vec;
    assign free_any = ~&vld;
    assign own_hit  = hit_any && (own[hit_idx] == owner);
    assign clr_now  = hit_any && (do_kill || (do_wclr && own_hit));
    assign slot     = hit_any ? hit_idx : (free_any ? free_idx : victim_idx);

    always_comb begin
        if (hit_any)       ref_age = {1'b0, age[hit_idx]};
        else if (free_any) ref_age = REF_W'(ENTRIES);
        else               ref_age = {1'b0, age[victim_idx]};
    end

    // valid bits and age ranks: rank 0 is the most recently armed entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
            for (int i = 0; i < ENTRIES; i++) age[i] <= '0;
        end else if (do_ll) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == slot) begin
                    vld[i] <= 1'b1;
                    age[i] <= '0;
                end else if (vld[i] && ({1'b0, age[i]} < ref_age)) begin
                    age[i] <= age[i] + 1'b1;
                end
            end
        end else if (clr_now) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == hit_idx) begin
                    vld[i] <= 1'b0;
                end else if (vld[i] && (age[i] > age[hit_idx])) begin
                    age[i] <= age[i] - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_ll) begin
            tag[slot] <= line;
            own[slot] <= owner;
        end
    end

    always_comb begin
        probe_hit   = 1'b0;
        probe_owner = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vld[i] && (tag[i] == probe_line)) begin
                probe_hit   = 1'b1;
                probe_owner = own[i];
            end
        end
    end

    always_comb begin
        count = '0;
        for (int i = 0; i < ENTRIES; i++) count = count + CNT_W'(vld[i]);
    end

endmodule

// File: rtl/llsc_line_lock.sv
module llsc_line_lock
    import llsc_pkg::*;
#(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_take,
    input  logic              lk_free,
    input  logic [LINE_W-1:0] line,
    input  logic [LINE_W-1:0] probe_line,
    output logic              probe_blocked
);
    lock_state_e       state, state_nx;
    logic [LINE_W-1:0] held_line;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_OPEN: if (lk_take) state_nx = S_HELD;
            S_HELD: if (lk_free && (line == held_line)) state_nx = S_OPEN;
            default: state_nx = S_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_OPEN;
            held_line <= '0;
        end else begin
            state <= state_nx;
            if (state == S_OPEN && lk_take) held_line <= line;
        end
    end

    always_comb begin
        unique case (state)
            S_OPEN:  probe_blocked = 1'b0;
            S_HELD:  probe_blocked = (probe_line == held_line);
            default: probe_blocked = 1'b0;
        endcase
    end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int LINE_W  = 26,
    parameter int ID_W    = 4,
    parameter int ENTRIES = 4,
    parameter int WORD_W  = 32,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              cmp_valid,
    input  logic [2:0]        cmp_kind,
    input  logic [LINE_W-1:0] cmp_line,
    input  logic [ID_W-1:0]   cmp_owner,
    input  logic [LINE_W-1:0] probe_line,
    output logic              sc_done,
    output logic [WORD_W-1:0] sc_word,
    output logic              probe_reserved,
    output logic [ID_W-1:0]   probe_owner,
    output logic              probe_blocked,
    output logic [CNT_W-1:0]  resv_count
);
    logic is_ll, is_sc, is_wr, is_lkrd, is_lkwr;
    logic own_hit;

    always_comb begin
        is_ll = 1'b0; is_sc = 1'b0; is_wr = 1'b0; is_lkrd = 1'b0; is_lkwr = 1'b0;
        if (cmp_valid) begin
            unique case (cmp_kind)
                K_LL:    is_ll   = 1'b1;
                K_SC:    is_sc   = 1'b1;
                K_WR:    is_wr   = 1'b1;
                K_LKRD:  is_lkrd = 1'b1;
                K_LKWR:  is_lkwr = 1'b1;
                default: ;
            endcase
        end
    end

    llsc_resv_table #(.LINE_W(LINE_W), .ID_W(ID_W), .ENTRIES(ENTRIES)) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .do_ll       (is_ll && !bypass),
        .do_kill     (is_sc && !bypass),
        .do_wclr     ((is_wr || is_lkrd || is_lkwr) && !bypass),
        .line        (cmp_line),
        .owner       (cmp_owner),
        .probe_line  (probe_line),
        .own_hit     (own_hit),
        .probe_hit   (probe_reserved),
        .probe_owner (probe_owner),
        .count       (resv_count)
    );

    llsc_line_lock #(.LINE_W(LINE_W)) u_lock (
        .clk           (clk),
        .rst_n         (rst_n),
        .lk_take       (is_lkrd),
        .lk_free       (is_lkwr),
        .line          (cmp_line),
        .probe_line    (probe_line),
        .probe_blocked (probe_blocked)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_done <= 1'b0;
            sc_word <= '0;
        end else begin
            sc_done <= is_sc;
            sc_word <= (is_sc && (bypass || own_hit)) ? WORD_W'(1) : '0;
        end
    end

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int LINE_W  = 26,
    parameter int ID_W    = 4,
    parameter int ENTRIES = 4,
    parameter int WORD_W  = 32,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bypass,
    input logic              cmp_valid,
    input logic [2:0]        cmp_kind,
    input logic [LINE_W-1:0] cmp_line,
    input logic [ID_W-1:0]   cmp_owner,
    input logic [LINE_W-1:0] probe_line,
    input logic              sc_done,
    input logic [WORD_W-1:0] sc_word,
    input logic              probe_reserved,
    input logic [ID_W-1:0]   probe_owner,
    input logic              probe_blocked,
    input logic [CNT_W-1:0]  resv_count
);
    p_sc_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_kind == 3'd1) |=> sc_done);

    p_no_stray_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_valid && cmp_kind == 3'd1) |=> !sc_done);

    p_word_binary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sc_done |-> (sc_word <= WORD_W'(1)));

    p_ll_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_kind == 3'd0 && !bypass) |=>
        (probe_line != $past(cmp_line) ||
         (probe_reserved && probe_owner == $past(cmp_owner))));

    p_sc_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_kind == 3'd1 && !bypass) |=>
        (probe_line != $past(cmp_line) || !probe_reserved));

    p_bypass_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_kind == 3'd1 && bypass) |=> (sc_word == WORD_W'(1)));

    p_bypass_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> $stable(resv_count));

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_kind == 3'd4) |=>
        (probe_line != $past(cmp_line) || !probe_blocked));

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resv_count <= CNT_W'(ENTRIES));

endmodule

bind llsc_monitor llsc_monitor_chk #(
    .LINE_W(LINE_W), .ID_W(ID_W), .ENTRIES(ENTRIES), .WORD_W(WORD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .cmp_valid(cmp_valid),
    .cmp_kind(cmp_kind), .cmp_line(cmp_line), .cmp_owner(cmp_owner),
    .probe_line(probe_line), .sc_done(sc_done), .sc_word(sc_word),
    .probe_reserved(probe_reserved), .probe_owner(probe_owner),
    .probe_blocked(probe_blocked), .resv_count(resv_count)
);

// File: tb/llsc_monitor_test.sv
`timescale 1ns/1ps
module llsc_monitor_test;
    localparam int LINE_W = 26, ID_W = 4, ENTRIES = 4, WORD_W = 32;
    localparam int CNT_W  = $clog2(ENTRIES + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bypass = 1'b0;
    logic              cmp_valid = 1'b0;
    logic [2:0]        cmp_kind = '0;
    logic [LINE_W-1:0] cmp_line = '0;
    logic [ID_W-1:0]   cmp_owner = '0;
    logic [LINE_W-1:0] probe_line = '0;
    logic              sc_done;
    logic [WORD_W-1:0] sc_word;
    logic              probe_reserved;
    logic [ID_W-1:0]   probe_owner;
    logic              probe_blocked;
    logic [CNT_W-1:0]  resv_count;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [WORD_W-1:0] exp_q [$];

    always #10 clk = ~clk;

    llsc_monitor #(.LINE_W(LINE_W), .ID_W(ID_W), .ENTRIES(ENTRIES), .WORD_W(WORD_W)) uut (
        .clk(clk), .rst_n(rst_n), .bypass(bypass), .cmp_valid(cmp_valid),
        .cmp_kind(cmp_kind), .cmp_line(cmp_line), .cmp_owner(cmp_owner),
        .probe_line(probe_line), .sc_done(sc_done), .sc_word(sc_word),
        .probe_reserved(probe_reserved), .probe_owner(probe_owner),
        .probe_blocked(probe_blocked), .resv_count(resv_count)
    );

    // monitor: every result pulse is matched against the scoreboard (R2, R9)
    always @(negedge clk) begin
        if (rst_n && sc_done) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R2/R9 unexpected result pulse: actual=%0d expected=none", sc_word);
            end else begin
                logic [WORD_W-1:0] e;
                e = exp_q.pop_front();
                if (sc_word !== e) begin
                    bad++;
                    $display("FAIL R2 result word: actual=%0d expected=%0d", sc_word, e);
                end
            end
        end
    end

    task automatic op(input logic [2:0] k, input int line, input int who);
        cmp_valid = 1'b1;
        cmp_kind  = k;
        cmp_line  = LINE_W'(line);
        cmp_owner = ID_W'(who);
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic sc(input int line, input int who, input int e);
        exp_q.push_back(WORD_W'(e));
        op(3'd1, line, who);
    endtask

    task automatic look(input int line, input bit e_res, input int e_own,
                        input bit e_blk, input string req);
        probe_line = LINE_W'(line);
        #1;
        total++;
        if (probe_reserved !== e_res || probe_blocked !== e_blk ||
            (e_res && probe_owner !== ID_W'(e_own))) begin
            bad++;
            $display("FAIL %s line %0d: actual res=%0d own=%0d blk=%0d expected res=%0d own=%0d blk=%0d",
                     req, line, probe_reserved, probe_owner, probe_blocked, e_res, e_own, e_blk);
        end
    endtask

    task automatic cnt(input int e, input string req);
        total++;
        if (resv_count !== CNT_W'(e)) begin
            bad++;
            $display("FAIL %s count: actual=%0d expected=%0d", req, resv_count, e);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog: actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: state after reset
        look(10, 0, 0, 0, "R8");
        cnt(0, "R8");
        total++;
        if (sc_done !== 1'b0) begin
            bad++;
            $display("FAIL R8 sc_done: actual=%0d expected=0", sc_done);
        end
        @(negedge clk);

        // R1, R2, R3
        op(3'd0, 10, 1);
        look(10, 1, 1, 0, "R1");
        cnt(1, "R1");
        sc(10, 1, 1);
        look(10, 0, 0, 0, "R3");
        sc(10, 1, 0);

        // R3: non-owner store-conditional fails and still clears
        op(3'd0, 20, 2);
        sc(20, 3, 0);
        look(20, 0, 0, 0, "R3");
        sc(20, 2, 0);

        // R4: only same-owner writes to the same line clear
        op(3'd0, 30, 1);
        op(3'd2, 30, 2);
        look(30, 1, 1, 0, "R4");
        op(3'd2, 31, 1);
        look(30, 1, 1, 0, "R4");
        op(3'd2, 30, 1);
        look(30, 0, 0, 0, "R4");
        op(3'd0, 30, 1);
        sc(30, 1, 1);

        // R1: ownership moves to a later load-linked
        op(3'd0, 40, 1);
        op(3'd0, 40, 2);
        look(40, 1, 2, 0, "R1");
        cnt(1, "R1");
        sc(40, 1, 0);
        cnt(0, "R3");

        // R5: eviction order with refresh and free slot
        for (int i = 1; i <= 4; i++) op(3'd0, i, 5);
        cnt(4, "R5");
        op(3'd0, 5, 5);
        look(1, 0, 0, 0, "R5");
        look(2, 1, 5, 0, "R5");
        op(3'd0, 2, 5);
        op(3'd0, 6, 5);
        look(3, 0, 0, 0, "R5");
        look(2, 1, 5, 0, "R5");
        sc(4, 5, 1);
        cnt(3, "R5");
        op(3'd0, 7, 5);
        look(5, 1, 5, 0, "R5");
        look(6, 1, 5, 0, "R5");
        look(7, 1, 5, 0, "R5");
        cnt(4, "R5");
        sc(2, 5, 1);
        sc(5, 5, 1);
        sc(6, 5, 1);
        sc(7, 5, 1);
        cnt(0, "R5");

        // R6: line blocking
        op(3'd3, 50, 1);
        look(50, 0, 0, 1, "R6");
        look(51, 0, 0, 0, "R6");
        op(3'd3, 52, 1);
        look(52, 0, 0, 0, "R6");
        op(3'd4, 51, 1);
        look(50, 0, 0, 1, "R6");
        op(3'd4, 50, 1);
        look(50, 0, 0, 0, "R6");
        // R4: locked read clears the same owner's reservation
        op(3'd0, 60, 3);
        op(3'd3, 60, 3);
        look(60, 0, 0, 1, "R4");
        op(3'd4, 60, 3);
        look(60, 0, 0, 0, "R6");

        // R7: bypass
        op(3'd0, 85, 1);
        bypass = 1'b1;
        op(3'd0, 70, 1);
        look(70, 0, 0, 0, "R7");
        cnt(1, "R7");
        sc(80, 2, 1);
        op(3'd2, 85, 1);
        sc(85, 1, 1);
        look(85, 1, 1, 0, "R7");
        op(3'd3, 90, 1);
        look(90, 0, 0, 1, "R7");
        op(3'd4, 90, 1);
        look(90, 0, 0, 0, "R7");
        bypass = 1'b0;
        sc(70, 1, 0);
        sc(85, 1, 1);

        // R9: unused codes
        op(3'd0, 95, 4);
        op(3'd5, 95, 4);
        op(3'd6, 95, 4);
        op(3'd7, 95, 4);
        look(95, 1, 4, 0, "R9");
        cnt(1, "R9");

        // R8: reset mid-run
        op(3'd3, 98, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(95, 0, 0, 0, "R8");
        look(98, 0, 0, 0, "R8");
        cnt(0, "R8");

        repeat (3) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R2 missing results: actual=%0d pending expected=0", exp_q.size());
        end
        summary();
    end
endmodule